// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the vector-configuration instruction of a vector unit. The decoder hands it three things: flags that tell whether the destination and the first source register are x0, the requested application vector length (AVL), and a requested vtype word. The unit holds the architectural vector length (vl) and vtype state. It derives the maximum vector length (VLMAX) from the `VLEN` parameter and the requested element width and register grouping. It returns a destination-register value with a write enable.

Within the vtype word, the grouping code sits in bits 2:0 and the element-width code in bits 5:3. The tail policy is bit 6 and the mask policy is bit 7. Bit XLEN-1 is the illegal flag, and every other bit must be zero.

The unit also handles the keep-vl form, where both registers are x0. In that form the current vl is reused, and the only legal use is one that leaves VLMAX unchanged. The form is reserved in two cases: when the new configuration would change VLMAX, and when the state was already illegal. In both cases, as with any unsupported configuration, the unit writes vtype as the illegal flag alone and clears vl.

Top module: `vcfg_unit`

## Requirements
- R1: While reset is low and after it, vl_o is 0, vtype_o has only bit XLEN-1 set, and rd_we_o is 0.
- R2: State and outputs change only at the clock edge that samples valid_i high. At any edge with valid_i low, vl_o and vtype_o keep their values and rd_we_o is 0 in the following cycle.
- R3: When rs1 is not x0 and the configuration is legal, vl becomes min(AVL, VLMAX). rd_data_o carries that same value.
- R4: When rs1 is x0 and rd is not x0, a legal configuration sets vl to VLMAX, and VLMAX is returned on rd_data_o.
- R5: VLMAX = VLEN*LMUL/SEW. The element-width codes 0..3 select SEW 8, 16, 32 and 64. The grouping codes select LMUL as follows: 0..3 give 1, 2, 4 and 8; 5, 6 and 7 give 1/8, 1/4 and 1/2.
- R6: A keep-vl request (rd and rs1 both x0) whose legal new configuration gives the same VLMAX as the current one is accepted. vtype_o takes the requested word, vl_o is unchanged, and rd_we_o stays 0.
- R7: A keep-vl request whose new configuration would change VLMAX sets the illegal flag.
- R8: A keep-vl request issued while the illegal flag is already 1 leaves the flag set, whatever configuration is requested.
- R9: The following configurations are illegal: an element-width code of 4 or above, a grouping code of 4, SEW above ELEN, SEW above LMUL*ELEN for fractional LMUL, VLMAX below 1, and any nonzero bit outside bits 7:0.
- R10: An illegal result sets vtype_o to bit XLEN-1 alone and vl_o to 0. When rd is written, it receives 0.
- R11: rd_we_o is 1 for exactly one cycle after an accepted request with rd not x0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| rd_zero_i | input | 1 | Destination register is x0 |
| rs1_zero_i | input | 1 | First source register is x0 |
| avl_i | input | XLEN | Requested vector length from rs1 |
| vtype_req_i | input | XLEN | Requested vtype word |
| vl_o | output | XLEN | Architectural vl |
| vtype_o | output | XLEN | Architectural vtype |
| rd_we_o | output | 1 | Destination register write enable |
| rd_data_o | output | XLEN | Destination register write value |

## Verification
Every result is registered once. vl_o, vtype_o, rd_we_o and rd_data_o all reflect a request in the cycle after the rising edge that samples valid_i, and rd_we_o falls again one cycle later. The bench changes inputs on the falling edge and holds valid_i for one cycle. It reads the outputs on the next falling edge, which is half a period after the edge that registers them. The idle test moves the inputs while valid_i is low and reads the same falling edge, which shows that no edge without the strobe changes the state.

// File: rtl/vcfg_pkg.sv
`timescale 1ns/1ps
// Package: vcfg_pkg
// Field positions of the vtype word and the conversion of the grouping
// code to a signed log2 value. Assumes XLEN >= 16.
package vcfg_pkg;
    localparam int LMUL_LO  = 0;
    localparam int SEW_LO   = 3;
    localparam int TA_BIT   = 6;
    localparam int MA_BIT   = 7;
    localparam int USED_TOP = 7;

    // Grouping code to log2(LMUL): 0..3 are whole multiples, 5..7 are fractions.
    function automatic int lmul_log2(input logic [2:0] code);
        return (code >= 3'd5) ? (int'(code) - 8) : int'(code);
    endfunction
endpackage

// File: rtl/vcfg_vtype_dec.sv
`timescale 1ns/1ps
// Module: vcfg_vtype_dec
// Checks a vtype word for a supported configuration and computes its
// VLMAX = VLEN*LMUL/SEW as a power of two. Assumes VLEN and ELEN are
// powers of two. Purely combinational.
module vcfg_vtype_dec
    import vcfg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLEN = 128,
    parameter int ELEN = 64
) (
    input  logic [XLEN-1:0] vtype_i,
    output logic            legal_o,
    output logic [XLEN-1:0] vlmax_o
);
    localparam int VLEN_LG = $clog2(VLEN);
    localparam int ELEN_LG = $clog2(ELEN);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    logic [2:0] lmul_code;
    logic [2:0] sew_code;
    int         lmul_lg;
    int         vlmax_lg;
    logic       fits_elen;

    assign lmul_code = vtype_i[LMUL_LO +: 3];
    assign sew_code  = vtype_i[SEW_LO +: 3];

    // Derive legality and VLMAX from the two size codes.
    always_comb begin
        lmul_lg   = lmul_log2(lmul_code);
        vlmax_lg  = VLEN_LG + lmul_lg - 3 - int'(sew_code);
        fits_elen = (int'(sew_code) + 3) <= (ELEN_LG + ((lmul_lg < 0) ? lmul_lg : 0));
        legal_o   = !sew_code[2] && (lmul_code != 3'd4) && fits_elen &&
                    (vlmax_lg >= 0) && (vtype_i[XLEN-1:USED_TOP+1] == '0);
        vlmax_o   = legal_o ? (ONE << vlmax_lg) : '0;
    end
endmodule

// File: rtl/vcfg_next.sv
`timescale 1ns/1ps
// Module: vcfg_next
// Next-state logic for vl and vtype. Chooses among the keep-vl, set-to-VLMAX
// and AVL forms, and marks reserved uses and illegal configurations.
// Assumes the stored vtype is either legal or the illegal word alone.
module vcfg_next #(
    parameter int XLEN = 64
) (
    input  logic            rd_zero_i,
    input  logic            rs1_zero_i,
    input  logic [XLEN-1:0] avl_i,
    input  logic [XLEN-1:0] req_vtype_i,
    input  logic            req_legal_i,
    input  logic [XLEN-1:0] req_vlmax_i,
    input  logic [XLEN-1:0] cur_vl_i,
    input  logic            cur_legal_i,
    input  logic [XLEN-1:0] cur_vlmax_i,
    output logic [XLEN-1:0] vl_o,
    output logic [XLEN-1:0] vtype_o
);
    localparam logic [XLEN-1:0] ILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

    logic keep_vl;
    logic reserved;

    assign keep_vl  = rd_zero_i && rs1_zero_i;
    assign reserved = keep_vl && (!cur_legal_i || (req_vlmax_i != cur_vlmax_i));

    // Select the new vl and vtype for this request.
    always_comb begin
        if (!req_legal_i || reserved) begin
            vtype_o = ILL_WORD;
            vl_o    = '0;
        end else begin
            vtype_o = req_vtype_i;
            if (keep_vl)
                vl_o = cur_vl_i;
            else if (rs1_zero_i)
                vl_o = req_vlmax_i;
            else
                vl_o = (avl_i < req_vlmax_i) ? avl_i : req_vlmax_i;
        end
    end
endmodule

// File: rtl/vcfg_unit.sv
`timescale 1ns/1ps
// Module: vcfg_unit
// Vector length configuration unit. Holds vl and vtype, and on each valid
// request registers the new state and the rd write. Results appear one
// cycle after the strobe. Synchronous active-low reset leaves the state
// illegal with vl = 0.
module vcfg_unit #(
    parameter int XLEN = 64,
    parameter int VLEN = 128,
    parameter int ELEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic            rd_zero_i,
    input  logic            rs1_zero_i,
    input  logic [XLEN-1:0] avl_i,
    input  logic [XLEN-1:0] vtype_req_i,
    output logic [XLEN-1:0] vl_o,
    output logic [XLEN-1:0] vtype_o,
    output logic            rd_we_o,
    output logic [XLEN-1:0] rd_data_o
);
    localparam logic [XLEN-1:0] ILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

    logic [XLEN-1:0] vl_q, vtype_q, data_q;
    logic            we_q;
    logic            req_legal, cur_legal;
    logic [XLEN-1:0] req_vlmax, cur_vlmax;
    logic [XLEN-1:0] vl_n, vtype_n;

    vcfg_vtype_dec #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u_req_dec (
        .vtype_i (vtype_req_i),
        .legal_o (req_legal),
        .vlmax_o (req_vlmax)
    );

    vcfg_vtype_dec #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u_cur_dec (
        .vtype_i (vtype_q),
        .legal_o (cur_legal),
        .vlmax_o (cur_vlmax)
    );

    vcfg_next #(.XLEN(XLEN)) u_next (
        .rd_zero_i   (rd_zero_i),
        .rs1_zero_i  (rs1_zero_i),
        .avl_i       (avl_i),
        .req_vtype_i (vtype_req_i),
        .req_legal_i (req_legal),
        .req_vlmax_i (req_vlmax),
        .cur_vl_i    (vl_q),
        .cur_legal_i (cur_legal),
        .cur_vlmax_i (cur_vlmax),
        .vl_o        (vl_n),
        .vtype_o     (vtype_n)
    );

    // Architectural state and rd write port, updated on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q    <= '0;
            vtype_q <= ILL_WORD;
            we_q    <= 1'b0;
            data_q  <= '0;
        end else begin
            we_q <= valid_i && !rd_zero_i;
            if (valid_i) begin
                vl_q    <= vl_n;
                vtype_q <= vtype_n;
                data_q  <= vl_n;
            end
        end
    end

    assign vl_o      = vl_q;
    assign vtype_o   = vtype_q;
    assign rd_we_o   = we_q;
    assign rd_data_o = data_q;
endmodule

// File: rtl/vcfg_unit_chk.sv
`timescale 1ns/1ps
// Module: vcfg_unit_chk
// Assertion checker bound to vcfg_unit. Observes its ports only.
module vcfg_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_i,
    input logic            rd_zero_i,
    input logic            rs1_zero_i,
    input logic [XLEN-1:0] avl_i,
    input logic [XLEN-1:0] vl_o,
    input logic [XLEN-1:0] vtype_o,
    input logic            rd_we_o,
    input logic [XLEN-1:0] rd_data_o
);
    logic past_ok;

    // Marks that at least one cycle has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r10_ill_clean: assert property (@(posedge clk) disable iff (!rst_n)
        vtype_o[XLEN-1] |-> (vtype_o[XLEN-2:0] == '0) && (vl_o == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(valid_i)) |-> ($stable(vl_o) && $stable(vtype_o) && !rd_we_o));

    a_r11_we_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> (past_ok && $past(valid_i) && !$past(rd_zero_i)));

    a_r3_avl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(valid_i && !rs1_zero_i)) |-> (vl_o <= $past(avl_i)));

    a_r3_rd_matches_vl: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> (rd_data_o == vl_o));

    a_r6_keep_vl: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(valid_i && rd_zero_i && rs1_zero_i) && !vtype_o[XLEN-1])
        |-> (vl_o == $past(vl_o)));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(valid_i && rd_zero_i && rs1_zero_i && vtype_o[XLEN-1]))
        |-> vtype_o[XLEN-1]);
endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .rd_zero_i  (rd_zero_i),
    .rs1_zero_i (rs1_zero_i),
    .avl_i      (avl_i),
    .vl_o       (vl_o),
    .vtype_o    (vtype_o),
    .rd_we_o    (rd_we_o),
    .rd_data_o  (rd_data_o)
);

// File: tb/vcfg_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for vcfg_unit: one task per scenario, each checking itself.
module vcfg_unit_tb;
    localparam int XLEN = 64;
    localparam logic [XLEN-1:0] ILL = {1'b1, {(XLEN-1){1'b0}}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid_i = 1'b0;
    logic            rd_zero_i = 1'b1;
    logic            rs1_zero_i = 1'b1;
    logic [XLEN-1:0] avl_i = '0;
    logic [XLEN-1:0] vtype_req_i = '0;
    logic [XLEN-1:0] vl_o, vtype_o, rd_data_o;
    logic            rd_we_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vcfg_unit #(.XLEN(XLEN), .VLEN(128), .ELEN(64)) u_dut (
        .clk (clk), .rst_n (rst_n), .valid_i (valid_i),
        .rd_zero_i (rd_zero_i), .rs1_zero_i (rs1_zero_i),
        .avl_i (avl_i), .vtype_req_i (vtype_req_i),
        .vl_o (vl_o), .vtype_o (vtype_o),
        .rd_we_o (rd_we_o), .rd_data_o (rd_data_o)
    );

    function automatic logic [XLEN-1:0] vt(input int sew, input int lmul, input bit ta, input bit ma);
        return XLEN'(lmul & 7) | (XLEN'(sew & 7) << 3) | (XLEN'(ta) << 6) | (XLEN'(ma) << 7);
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request; returns on the falling edge after the registering edge.
    task automatic issue(input bit rdz, input bit rs1z, input logic [XLEN-1:0] avl, input logic [XLEN-1:0] vtw);
        @(negedge clk);
        rd_zero_i = rdz; rs1_zero_i = rs1z; avl_i = avl; vtype_req_i = vtw; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 vl", vl_o, '0);
        chk("R1 vtype", vtype_o, ILL);
        chk("R1 we", XLEN'(rd_we_o), '0);
    endtask

    task automatic t_vlmax_form;
        issue(0, 1, '0, vt(3, 3, 1, 1));           // e64 m8 -> 16
        chk("R4 vl", vl_o, 64'd16);
        chk("R5 vtype", vtype_o, vt(3, 3, 1, 1));
        chk("R11 we", XLEN'(rd_we_o), 64'd1);
        chk("R4 rd", rd_data_o, 64'd16);
        @(negedge clk);
        chk("R11 we drops", XLEN'(rd_we_o), '0);
    endtask

    task automatic t_keep_same;
        issue(1, 1, '0, vt(3, 3, 1, 1));
        chk("R6 vl", vl_o, 64'd16);
        chk("R6 vtype", vtype_o, vt(3, 3, 1, 1));
        chk("R6 no we", XLEN'(rd_we_o), '0);
        issue(1, 1, '0, vt(2, 2, 0, 1));           // e32 m4, same ratio
        chk("R6 ratio vtype", vtype_o, vt(2, 2, 0, 1));
        chk("R6 ratio vl", vl_o, 64'd16);
    endtask

    task automatic t_keep_change;
        issue(1, 1, '0, vt(3, 0, 1, 1));           // e64 m1 -> VLMAX 2
        chk("R7 vtype", vtype_o, ILL);
        chk("R10 vl", vl_o, '0);
    endtask

    task automatic t_keep_while_ill;
        issue(1, 1, '0, vt(0, 0, 0, 0));
        chk("R8 vtype", vtype_o, ILL);
        chk("R8 vl", vl_o, '0);
    endtask

    task automatic t_avl_form;
        issue(0, 0, 64'd5, vt(0, 0, 0, 0));        // e8 m1, VLMAX 16
        chk("R3 small avl", vl_o, 64'd5);
        chk("R3 rd", rd_data_o, 64'd5);
        chk("R3 vtype", vtype_o, vt(0, 0, 0, 0));
        issue(0, 0, 64'd1000, vt(2, 0, 1, 0));     // e32 m1, VLMAX 4
        chk("R3 clamp", vl_o, 64'd4);
        issue(0, 0, 64'd100, vt(1, 7, 0, 0));      // e16 mf2, VLMAX 4
        chk("R5 fractional", vl_o, 64'd4);
        issue(0, 1, '0, vt(0, 3, 0, 0));           // e8 m8 -> 128
        chk("R5 max", vl_o, 64'd128);
        issue(0, 0, '0, vt(0, 0, 0, 0));
        chk("R3 zero avl", vl_o, '0);
    endtask

    task automatic t_rd_zero_avl;
        issue(1, 0, 64'd3, vt(0, 0, 0, 0));
        chk("R3 vl rd x0", vl_o, 64'd3);
        chk("R11 no we rd x0", XLEN'(rd_we_o), '0);
    endtask

    task automatic t_illegal_codes;
        issue(0, 0, 64'd7, vt(4, 0, 0, 0));
        chk("R9 sew code", vtype_o, ILL);
        chk("R10 rd zero", rd_data_o, '0);
        chk("R10 we", XLEN'(rd_we_o), 64'd1);
        issue(0, 0, 64'd1, vt(2, 0, 0, 0));
        issue(0, 0, 64'd7, vt(0, 4, 0, 0));
        chk("R9 lmul code", vtype_o, ILL);
        issue(0, 0, 64'd1, vt(2, 0, 0, 0));
        issue(0, 0, 64'd7, vt(3, 7, 0, 0));        // e64 mf2: SEW > LMUL*ELEN
        chk("R9 frac elen", vtype_o, ILL);
        issue(0, 0, 64'd1, vt(2, 0, 0, 0));
        issue(0, 0, 64'd7, vt(0, 0, 0, 0) | (XLEN'(1) << 8));
        chk("R9 reserved bit", vtype_o, ILL);
        chk("R10 vl", vl_o, '0);
    endtask

    task automatic t_idle;
        issue(0, 0, 64'd9, vt(0, 0, 0, 0));
        @(negedge clk);
        rd_zero_i = 0; rs1_zero_i = 1; vtype_req_i = vt(4, 4, 1, 1); avl_i = 64'd2;
        @(negedge clk);
        @(negedge clk);
        chk("R2 vl held", vl_o, 64'd9);
        chk("R2 vtype held", vtype_o, vt(0, 0, 0, 0));
        chk("R2 no we", XLEN'(rd_we_o), '0);
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vlmax_form();
        t_keep_same();
        t_keep_change();
        t_keep_while_ill();
        t_avl_form();
        t_rd_zero_avl();
        t_illegal_codes();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule